// File: doc/BRIEF.md
# Page buffer write controller

This block gathers the data bytes of one write transaction into a page-sized buffer and, once the bus reports a stop condition, copies the whole page into the storage array during a self-timed busy period. The bus engine in front of it supplies three things: a pointer-load strobe carrying the transaction's start address, a strobe for each data byte it receives, and a stop strobe. A write-protect level is also sampled. The array is a synchronous RAM outside the block, with one read port and one write port. The block uses the read port to fetch bytes the transaction did not supply, so that every location in the page is rewritten with either new data or its old value.

Bytes only advance the low offset bits of the pointer. A transaction that runs past the last byte of its page wraps to the first byte of the same page and overwrites bytes it received earlier. While the commit runs, `busy` is high and the block ignores everything from the bus side. The commit length is a parameter counted in system clocks.

Top module: `page_write_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `arr_rd_en` and `arr_wr_en` are all low.
- R2: The pointer loads from `start_addr`. Each data byte is stored at the current offset, and only the low log2(PAGE_BYTES) bits then increment. Offset PAGE_BYTES-1 is followed by offset 0 of the same page, and a later byte for an offset replaces the earlier one.
- R3: There is no array write before the stop strobe. `busy` rises on the first clock edge after a stop that starts a commit.
- R4: If `wp` is high when the stop strobe is sampled, no commit starts. `busy` stays low, the array is unchanged, and the next transaction is accepted at once.
- R5: A change of `wp` while `busy` is high does not alter the commit in progress.
- R6: A commit writes every one of the PAGE_BYTES locations of the page exactly once, in ascending offset order. Locations that got a byte take that byte. All others take their current array contents.
- R7: `busy` stays high for exactly WRITE_CYCLES clock cycles per commit.
- R8: A stop strobe that arrives when no byte has been received since the last pointer load starts no commit.
- R9: Pointer loads, data bytes and stop strobes that arrive while `busy` is high are ignored and have no effect on the array.
- R10: A pointer load throws away any bytes collected since the previous load. If a byte strobe and a pointer load arrive together, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Loads the pointer from start_addr and opens a transaction |
| start_addr | input | ADDR_W | Starting byte address of the transaction |
| byte_valid | input | 1 | One received data byte is present on byte_data |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write-protect level, sampled with stop |
| busy | output | 1 | Commit in progress |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | 8 | Array read data, one cycle after the request |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | 8 | Array write data |

## Verification
The main function is driven with five patterns:
- A short run in the middle of a page. This separates bytes that were received from bytes that were refreshed.
- A run starting near the page end, which has to wrap to offset 0.
- A run longer than a page, where wrapped bytes overwrite earlier ones.
- A full page starting at offset 0.
- Two pointer loads in one transaction, where only the second run may land.

Around these, the bench repeats a stop with write protect set, a stop with no data, write protect toggled during the commit, and bus traffic during the commit. Each of these must leave a different page or timing signature. After every commit it checks the busy length, the number of array writes, and both the target page and a neighbouring page.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_COMMIT  = 1'b1
  } pwc_state_t;
endpackage

// File: rtl/pwc_page_buf.sv
// Page staging memory: one write port, one registered read port (block RAM style).
module pwc_page_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwc_byte_mask.sv
// One flag per page offset, set when that offset has received a byte.
module pwc_byte_mask #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [AW-1:0] set_idx,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_bit,
  output logic          any_set
);
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst || clr) flags <= '0;
    else if (set)   flags[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else     rd_bit <= flags[rd_idx];
  end

  assign any_set = |flags;
endmodule

// File: rtl/pwc_cycle_timer.sv
// Counts clocks while active; flags the last cycle of the window.
module pwc_cycle_timer #(
  parameter int LIMIT = 128,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || !active) count <= '0;
    else                count <= count + 1'b1;
  end

  assign last = active && (count == CW'(LIMIT - 1));
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 128   // must be at least PAGE_BYTES + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [7:0]        arr_rd_data,
  output logic              arr_wr_en,
  output logic [ADDR_W-1:0] arr_wr_addr,
  output logic [7:0]        arr_wr_data
);
  import pwc_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  pwc_state_t       state;
  logic [PG_W-1:0]  page_base;
  logic [OFF_W-1:0] offset;
  logic [CNT_W-1:0] tcount;
  logic             tlast;
  logic             any_byte;
  logic             mask_bit_q;
  logic [7:0]       buf_q;

  logic collecting, take_load, take_byte, take_stop, start_commit, mask_clr;
  logic [OFF_W-1:0] scan_off;
  logic             scan_en;

  assign collecting   = (state == ST_COLLECT);
  assign take_load    = collecting && addr_load;
  assign take_byte    = collecting && byte_valid && !addr_load;
  assign take_stop    = collecting && stop;
  assign start_commit = take_stop && any_byte && !wp;
  assign mask_clr     = take_load || (take_stop && !start_commit) || tlast;

  assign scan_off = tcount[OFF_W-1:0];
  assign scan_en  = busy && (tcount < CNT_W'(PAGE_BYTES));

  // Pointer and control state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      page_base <= '0;
      offset    <= '0;
      busy      <= 1'b0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (take_load) begin
            page_base <= start_addr[ADDR_W-1:OFF_W];
            offset    <= start_addr[OFF_W-1:0];
          end else if (take_byte) begin
            offset <= offset + 1'b1;
          end
          if (start_commit) begin
            state <= ST_COMMIT;
            busy  <= 1'b1;
          end
        end
        ST_COMMIT: begin
          if (tlast) begin
            state <= ST_COLLECT;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  pwc_cycle_timer #(.LIMIT(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (busy),
    .count  (tcount),
    .last   (tlast)
  );

  pwc_byte_mask #(.DEPTH(PAGE_BYTES)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clr     (mask_clr),
    .set     (take_byte),
    .set_idx (offset),
    .rd_idx  (scan_off),
    .rd_bit  (mask_bit_q),
    .any_set (any_byte)
  );

  pwc_page_buf #(.DEPTH(PAGE_BYTES), .DW(BYTE_W)) u_buf (
    .clk   (clk),
    .we    (take_byte),
    .waddr (offset),
    .wdata (byte_data),
    .raddr (scan_off),
    .rdata (buf_q)
  );

  // Array read request: one offset per cycle for the first PAGE_BYTES cycles of busy
  assign arr_rd_en   = scan_en;
  assign arr_rd_addr = {page_base, scan_off};

  // Merge stage: buffer and array data arrive one cycle after the request
  logic             s1_valid;
  logic [OFF_W-1:0] s1_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_off      <= '0;
      arr_wr_en   <= 1'b0;
      arr_wr_addr <= '0;
      arr_wr_data <= '0;
    end else begin
      s1_valid    <= scan_en;
      s1_off      <= scan_off;
      arr_wr_en   <= s1_valid;
      arr_wr_addr <= {page_base, s1_off};
      arr_wr_data <= mask_bit_q ? buf_q : arr_rd_data;
    end
  end
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              stop,
  input logic              wp,
  input logic              busy,
  input logic              arr_rd_en,
  input logic              arr_wr_en,
  input logic [ADDR_W-1:0] arr_wr_addr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 2);

  logic             busy_d;
  logic [CNT_W-1:0] wr_seen;
  logic [CNT_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d   <= 1'b0;
      wr_seen  <= '0;
      busy_len <= '0;
    end else begin
      busy_d <= busy;
      if (!busy && !busy_d) wr_seen <= '0;
      else if (arr_wr_en)   wr_seen <= wr_seen + 1'b1;
      if (busy)         busy_len <= busy_len + 1'b1;
      else if (!busy_d) busy_len <= '0;
    end
  end

  assert_wr_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |-> busy);

  assert_rd_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    arr_rd_en |-> busy);

  assert_busy_needs_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop) && !$past(wp)));

  assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (stop && wp && !busy) |=> !busy);

  assert_ascending_R6: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_en && $past(arr_wr_en)) |->
      (arr_wr_addr[OFF_W-1:0] == $past(arr_wr_addr[OFF_W-1:0]) + 1'b1) &&
      (arr_wr_addr[ADDR_W-1:OFF_W] == $past(arr_wr_addr[ADDR_W-1:OFF_W])));

  assert_full_page_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_d && !busy) |-> (wr_seen == CNT_W'(PAGE_BYTES)));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_d && !busy) |-> (busy_len == CNT_W'(WRITE_CYCLES)));
endmodule

bind page_write_ctrl pwc_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_pwc_checker (
  .clk         (clk),
  .rst         (rst),
  .stop        (stop),
  .wp          (wp),
  .busy        (busy),
  .arr_rd_en   (arr_rd_en),
  .arr_wr_en   (arr_wr_en),
  .arr_wr_addr (arr_wr_addr)
);

// File: tb/page_write_ctrl_bench.sv
`timescale 1ns/1ps
module page_write_ctrl_bench;
  localparam int AW    = 10;
  localparam int PB    = 64;
  localparam int WC    = 128;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          stop = 1'b0;
  logic          wp = 1'b0;
  logic          busy, arr_rd_en, arr_wr_en;
  logic [AW-1:0] arr_rd_addr, arr_wr_addr;
  logic [7:0]    arr_rd_data, arr_wr_data;

  always #2.5 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_page_write_ctrl (
    .clk(clk), .rst(rst), .addr_load(addr_load), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
    .busy(busy), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data)
  );

  // Array model (synchronous RAM) and independent expected image
  logic [7:0] ram [WORDS];
  logic [7:0] exp_ram [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ram[i]     = 8'((i * 37 + 11) & 255);
      exp_ram[i] = 8'((i * 37 + 11) & 255);
    end
  end
  always @(posedge clk) begin
    if (arr_wr_en) ram[arr_wr_addr] <= arr_wr_data;
    if (arr_rd_en) arr_rd_data <= ram[arr_rd_addr];
  end

  // Port monitors, sampled at the falling edge
  int wr_seen = 0, busy_seen = 0, stray_wr = 0;
  always @(negedge clk) begin
    if (arr_wr_en) wr_seen++;
    if (busy) busy_seen++;
    if (arr_wr_en && !busy) stray_wr++;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Transaction model in the bench
  int  p_base, p_off;
  bit  p_mask [PB];
  logic [7:0] p_dat [PB];

  task automatic load(input int addr);
    @(negedge clk);
    addr_load = 1'b1; start_addr = AW'(addr);
    @(negedge clk);
    addr_load = 1'b0;
    p_base = addr / PB; p_off = addr % PB;
    for (int i = 0; i < PB; i++) p_mask[i] = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
    p_dat[p_off] = d; p_mask[p_off] = 1'b1; p_off = (p_off + 1) % PB;
  endtask

  // Issue stop; if a commit is expected, follow it to completion and check it
  task automatic finish(input bit wp_at_stop, input string req);
    bit any = 1'b0;
    for (int i = 0; i < PB; i++) if (p_mask[i]) any = 1'b1;
    wr_seen = 0; busy_seen = 0;
    wp = wp_at_stop; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    if (any && !wp_at_stop) begin
      check(busy == 1'b1, "R3", "busy one cycle after stop", int'(busy), 1);
      for (int i = 0; i < PB; i++)
        if (p_mask[i]) exp_ram[p_base * PB + i] = p_dat[i];
      for (int g = 0; g < 4 * WC && busy; g++) @(negedge clk);
      check(busy_seen == WC, "R7", "busy cycles", busy_seen, WC);
      check(wr_seen == PB, "R6", "array writes in commit", wr_seen, PB);
    end else begin
      check(busy == 1'b0, req, "busy after stop without commit", int'(busy), 0);
      repeat (WC + 4) @(negedge clk);
      check(wr_seen == 0, req, "array writes without commit", wr_seen, 0);
    end
    wp = 1'b0;
  endtask

  task automatic check_page(input int pg, input string req);
    int bad = -1;
    for (int i = 0; i < PB; i++)
      if (bad < 0 && ram[pg * PB + i] !== exp_ram[pg * PB + i]) bad = i;
    if (bad < 0) check(1'b1, req, "page contents", 0, 0);
    else check(1'b0, req, $sformatf("page %0d offset %0d", pg, bad),
               int'(ram[pg * PB + bad]), int'(exp_ram[pg * PB + bad]));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(busy == 1'b0 && arr_rd_en == 1'b0 && arr_wr_en == 1'b0, "R1",
          "outputs after reset", int'({busy, arr_rd_en, arr_wr_en}), 0);
  endtask

  task automatic t_partial;
    load(2 * PB + 5);
    wr_seen = 0;
    send(8'hA1); send(8'hA2); send(8'hA3);
    repeat (5) @(negedge clk);
    check(wr_seen == 0, "R3", "writes before stop", wr_seen, 0);
    finish(1'b0, "R3");
    check_page(2, "R2");
    check_page(3, "R6");
  endtask

  task automatic t_wrap;
    load(4 * PB + 62);
    for (int i = 0; i < 5; i++) send(8'(8'h50 + i));
    finish(1'b0, "R2");
    check_page(4, "R2");
    check_page(5, "R2");
  endtask

  task automatic t_overrun;
    load(6 * PB + 60);
    for (int i = 0; i < PB + 2; i++) send(8'(8'hC0 ^ i));
    finish(1'b0, "R2");
    check_page(6, "R2");
  endtask

  task automatic t_full;
    load(7 * PB);
    for (int i = 0; i < PB; i++) send(8'(255 - i));
    finish(1'b0, "R6");
    check_page(7, "R6");
  endtask

  task automatic t_protect;
    load(8 * PB + 10);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    finish(1'b1, "R4");
    check_page(8, "R4");
    load(8 * PB + 20);
    send(8'h77);
    finish(1'b0, "R4");
    check_page(8, "R4");
  endtask

  task automatic t_wp_during_busy;
    load(9 * PB + 3);
    send(8'h9A); send(8'h9B);
    fork
      finish(1'b0, "R5");
      begin
        repeat (3) @(negedge clk);
        wp = 1'b1;
        repeat (20) @(negedge clk);
        wp = 1'b0;
      end
    join
    check_page(9, "R5");
  endtask

  task automatic t_zero_bytes;
    load(10 * PB + 7);
    finish(1'b0, "R8");
    check_page(10, "R8");
  endtask

  task automatic t_busy_ignore;
    load(11 * PB);
    send(8'hE1);
    fork
      finish(1'b0, "R9");
      begin
        repeat (4) @(negedge clk);
        addr_load = 1'b1; start_addr = AW'(12 * PB);
        @(negedge clk);
        addr_load = 1'b0; byte_valid = 1'b1; byte_data = 8'h5A;
        @(negedge clk);
        byte_valid = 1'b0; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
      end
    join
    check_page(11, "R9");
    wr_seen = 0;
    repeat (WC + 4) @(negedge clk);
    check(busy == 1'b0 && wr_seen == 0, "R9", "activity after ignored traffic",
          wr_seen, 0);
    check_page(12, "R9");
  endtask

  task automatic t_reload;
    load(13 * PB + 1);
    send(8'h31); send(8'h32);
    load(14 * PB + 40);
    send(8'h3F);
    finish(1'b0, "R10");
    check_page(13, "R10");
    check_page(14, "R10");
    // byte strobe coincident with a pointer load must be dropped
    @(negedge clk);
    addr_load = 1'b1; start_addr = AW'(15 * PB + 8);
    byte_valid = 1'b1; byte_data = 8'hEE;
    @(negedge clk);
    addr_load = 1'b0; byte_valid = 1'b0;
    p_base = 15; p_off = 8;
    for (int i = 0; i < PB; i++) p_mask[i] = 1'b0;
    finish(1'b0, "R10");
    check_page(15, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_partial();
    t_wrap();
    t_overrun();
    t_full();
    t_protect();
    t_wp_during_busy();
    t_zero_bytes();
    t_busy_ignore();
    t_reload();
    check(stray_wr == 0, "R3", "array writes outside busy", stray_wr, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule